// File: doc/BRIEF.md
# Power-Fail Autostore and Recall Controller

This controller sits beside a volatile working array that has a nonvolatile shadow. It watches two already-synchronised supply comparator flags, one for the switch threshold and one for the lower reset threshold. When the supply sags below the switch threshold and the array has been written since its last save, the controller waits a short grace window so that a memory cycle already in flight can finish. It then runs a save as two timed phases: an erase of the old shadow contents, then a program of the new ones. While the supply is low, or while any of its own operations is running, it blocks further memory writes.

A restore request is latched at reset, which stands for power-up, and whenever the supply falls below the reset threshold. The restore runs once the supply is back above the switch threshold. It has two timed phases: a clear of the working array, then a transfer of the shadow contents into it. A brown-out that stays above the reset threshold therefore never causes a restore. A write-tracking flag decides whether a save is needed. Operations started by software are seen through a busy level and a completion pulse. The automatic operations wait for software to finish, and a software completion also counts as a save point.

Top module: `pfail_nv_ctrl`

## Requirements
- R1: When `vlow_sw` is high, the dirty flag is set and `sw_busy` is low, an automatic save starts. `auto_store_req` is high from the next cycle until the program phase ends. When the flag is clear, no save starts however long the supply stays low.
- R2: `wr_inhibit` is high whenever `vlow_sw` is high or an operation is running. A `wr_strobe` seen while `wr_inhibit` is high is ignored and does not set the dirty flag.
- R3: A restore request is latched by reset and by every cycle with `vlow_rst` high. While the request is pending and `sw_busy` is low, a restore starts on the first clock edge with `vlow_sw` low.
- R4: A dip in which `vlow_sw` goes high but `vlow_rst` stays low produces no restore when `vlow_sw` returns low.
- R5: A save is an erase phase of ERASE_CYC cycles (`ph_erase` high) followed directly by a program phase of PROG_CYC cycles (`ph_prog` high). At most one phase strobe is ever high.
- R6: A restore is a clear phase of CLEAR_CYC cycles (`ph_clear` high) followed directly by a transfer phase of XFER_CYC cycles (`ph_xfer` high). `recall_req` and `busy` are high throughout.
- R7: Before the erase phase, the save holds a grace window of DELAY_CYC cycles. During the window `busy` and `auto_store_req` are high and no phase strobe is high.
- R8: The dirty flag is set by an accepted write. It is cleared when a save or restore completes and by an `sw_done` pulse.
- R9: No automatic operation starts while `sw_busy` is high. A save that was held back starts on the first edge after `sw_busy` falls.
- R10: If a save and a restore are both pending while the supply is low, the save runs first. The restore runs once `vlow_sw` goes low.
- R11: While `rst` is high, `busy`, `auto_store_req`, `recall_req` and all phase strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, treated as power-up |
| vlow_sw | input | 1 | Supply below switch threshold (synchronised) |
| vlow_rst | input | 1 | Supply below reset threshold (synchronised) |
| wr_strobe | input | 1 | One pulse per memory write attempt |
| sw_busy | input | 1 | A software-initiated save or restore is running |
| sw_done | input | 1 | Pulse when a software-initiated save or restore completes |
| wr_inhibit | output | 1 | Memory writes must be blocked |
| busy | output | 1 | An automatic operation (grace, save or restore) is running |
| auto_store_req | output | 1 | Automatic save in progress (grace, erase or program) |
| recall_req | output | 1 | Restore in progress (clear or transfer) |
| ph_erase | output | 1 | Erase phase strobe |
| ph_prog | output | 1 | Program phase strobe |
| ph_clear | output | 1 | Array clear phase strobe |
| ph_xfer | output | 1 | Shadow-to-array transfer phase strobe |

## Verification
The assertions rely on physically ordered comparator flags: `vlow_rst` is high only while `vlow_sw` is also high, and both are already synchronised to `clk`. They also rely on `sw_done` arriving while `sw_busy` is still high. The stimulus respects these rules. Every table row raises `vlow_rst` together with `vlow_sw` and lowers it first. Software completion is always pulsed one cycle before the busy level drops. All inputs change on the falling edge, so each flag holds steady for a full cycle around the edge that samples it.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

    typedef enum logic [2:0] {
        PF_IDLE  = 3'd0,
        PF_GRACE = 3'd1,
        PF_ERASE = 3'd2,
        PF_PROG  = 3'd3,
        PF_CLEAR = 3'd4,
        PF_XFER  = 3'd5
    } pf_state_e;

    typedef struct packed {
        logic erase;
        logic prog;
        logic clear;
        logic xfer;
    } pf_phase_t;

    function automatic pf_phase_t phase_of(pf_state_e s);
        pf_phase_t p;
        p.erase = (s == PF_ERASE);
        p.prog  = (s == PF_PROG);
        p.clear = (s == PF_CLEAR);
        p.xfer  = (s == PF_XFER);
        return p;
    endfunction

    function automatic logic is_store(pf_state_e s);
        return (s == PF_GRACE) || (s == PF_ERASE) || (s == PF_PROG);
    endfunction

    function automatic logic is_recall(pf_state_e s);
        return (s == PF_CLEAR) || (s == PF_XFER);
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pfail_dirty.sv
module pfail_dirty (
    input  logic clk,
    input  logic rst,
    input  logic wr_acc,
    input  logic clr,
    output logic dirty
);

    // An accepted write in the same cycle as a completion counts after it.
    always_ff @(posedge clk) begin
        if (rst)
            dirty <= 1'b0;
        else if (wr_acc)
            dirty <= 1'b1;
        else if (clr)
            dirty <= 1'b0;
    end

    a_r8_set_by_write: assert property (@(posedge clk) disable iff (rst)
        $rose(dirty) |-> $past(wr_acc));

    a_r8_clear_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(dirty) |-> $past(clr));

endmodule

// File: rtl/pfail_recall_latch.sv
module pfail_recall_latch (
    input  logic clk,
    input  logic rst,
    input  logic vlow_rst,
    input  logic recall_start,
    output logic pend
);

    // Deep-dip capture wins over consumption in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b1;
        else if (vlow_rst)
            pend <= 1'b1;
        else if (recall_start)
            pend <= 1'b0;
    end

    a_r3_held_low_supply: assert property (@(posedge clk) disable iff (rst)
        $past(vlow_rst) |-> pend);

endmodule

// File: rtl/pfail_seq.sv
module pfail_seq
    import pfail_pkg::*;
#(
    parameter int DELAY_CYC = 3,
    parameter int ERASE_CYC = 4,
    parameter int PROG_CYC  = 5,
    parameter int CLEAR_CYC = 2,
    parameter int XFER_CYC  = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      vlow_sw,
    input  logic      sw_busy,
    input  logic      dirty,
    input  logic      recall_pend,
    output pf_state_e state,
    output logic      op_done,
    output logic      recall_start
);

    localparam int MAX_LEN = max_of(max_of(max_of(DELAY_CYC, ERASE_CYC),
                                           max_of(PROG_CYC, CLEAR_CYC)), XFER_CYC);
    localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_load;
    pf_state_e        nxt;

    function automatic logic [CNT_W-1:0] len_m1(pf_state_e s);
        int n;
        case (s)
            PF_GRACE: n = DELAY_CYC;
            PF_ERASE: n = ERASE_CYC;
            PF_PROG:  n = PROG_CYC;
            PF_CLEAR: n = CLEAR_CYC;
            PF_XFER:  n = XFER_CYC;
            default:  n = 1;
        endcase
        return CNT_W'(n - 1);
    endfunction

    always_comb begin
        nxt          = state;
        op_done      = 1'b0;
        recall_start = 1'b0;
        case (state)
            PF_IDLE: begin
                if (!sw_busy) begin
                    if (recall_pend && !vlow_sw) begin
                        nxt          = PF_CLEAR;
                        recall_start = 1'b1;
                    end else if (vlow_sw && dirty) begin
                        nxt = PF_GRACE;
                    end
                end
            end
            PF_GRACE: if (cnt == '0) nxt = PF_ERASE;
            PF_ERASE: if (cnt == '0) nxt = PF_PROG;
            PF_PROG: begin
                if (cnt == '0) begin
                    nxt     = PF_IDLE;
                    op_done = 1'b1;
                end
            end
            PF_CLEAR: if (cnt == '0) nxt = PF_XFER;
            PF_XFER: begin
                if (cnt == '0) begin
                    nxt     = PF_IDLE;
                    op_done = 1'b1;
                end
            end
            default: nxt = PF_IDLE;
        endcase
        cnt_load = len_m1(nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PF_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)
                cnt <= cnt_load;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    a_r9_hold_for_software: assert property (@(posedge clk) disable iff (rst)
        (state == PF_IDLE && sw_busy) |=> state == PF_IDLE);

    a_r4_recall_needs_latch: assert property (@(posedge clk) disable iff (rst)
        (state == PF_CLEAR && $past(state) == PF_IDLE) |-> $past(recall_pend));

    a_r7_erase_after_grace: assert property (@(posedge clk) disable iff (rst)
        (state == PF_ERASE && $past(state) != PF_ERASE) |-> $past(state) == PF_GRACE);

    a_r1_store_needs_dirty: assert property (@(posedge clk) disable iff (rst)
        (state == PF_GRACE && $past(state) == PF_IDLE) |-> $past(dirty && vlow_sw));

endmodule

// File: rtl/pfail_nv_ctrl.sv
module pfail_nv_ctrl
    import pfail_pkg::*;
#(
    parameter int DELAY_CYC = 3,
    parameter int ERASE_CYC = 4,
    parameter int PROG_CYC  = 5,
    parameter int CLEAR_CYC = 2,
    parameter int XFER_CYC  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic vlow_sw,
    input  logic vlow_rst,
    input  logic wr_strobe,
    input  logic sw_busy,
    input  logic sw_done,
    output logic wr_inhibit,
    output logic busy,
    output logic auto_store_req,
    output logic recall_req,
    output logic ph_erase,
    output logic ph_prog,
    output logic ph_clear,
    output logic ph_xfer
);

    pf_state_e state;
    pf_phase_t phase;
    logic      dirty;
    logic      recall_pend;
    logic      op_done;
    logic      recall_start;
    logic      wr_acc;

    assign busy           = (state != PF_IDLE);
    assign wr_inhibit     = vlow_sw | busy;
    assign wr_acc         = wr_strobe & ~wr_inhibit;
    assign auto_store_req = is_store(state);
    assign recall_req     = is_recall(state);
    assign phase          = phase_of(state);
    assign ph_erase       = phase.erase;
    assign ph_prog        = phase.prog;
    assign ph_clear       = phase.clear;
    assign ph_xfer        = phase.xfer;

    pfail_dirty u_dirty (
        .clk    (clk),
        .rst    (rst),
        .wr_acc (wr_acc),
        .clr    (op_done | sw_done),
        .dirty  (dirty)
    );

    pfail_recall_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .vlow_rst     (vlow_rst),
        .recall_start (recall_start),
        .pend         (recall_pend)
    );

    pfail_seq #(
        .DELAY_CYC (DELAY_CYC),
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC),
        .CLEAR_CYC (CLEAR_CYC),
        .XFER_CYC  (XFER_CYC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .vlow_sw      (vlow_sw),
        .sw_busy      (sw_busy),
        .dirty        (dirty),
        .recall_pend  (recall_pend),
        .state        (state),
        .op_done      (op_done),
        .recall_start (recall_start)
    );

    a_r2_inhibit_when_low: assert property (@(posedge clk) disable iff (rst)
        vlow_sw |-> wr_inhibit);

    a_r5_single_phase: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ph_erase, ph_prog, ph_clear, ph_xfer}));

    a_r5_erase_then_prog: assert property (@(posedge clk) disable iff (rst)
        $fell(ph_erase) |-> ph_prog);

    a_r6_clear_then_xfer: assert property (@(posedge clk) disable iff (rst)
        $fell(ph_clear) |-> ph_xfer);

    a_r6_recall_busy: assert property (@(posedge clk) disable iff (rst)
        recall_req |-> (busy && wr_inhibit));

endmodule

// File: tb/tb_pfail_nv_ctrl.sv
module tb_pfail_nv_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vlow_sw = 1'b1, vlow_rst = 1'b1, wr_strobe = 1'b0, sw_busy = 1'b0, sw_done = 1'b0;
    logic wr_inhibit, busy, auto_store_req, recall_req;
    logic ph_erase, ph_prog, ph_clear, ph_xfer;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pfail_nv_ctrl dut (
        .clk(clk), .rst(rst), .vlow_sw(vlow_sw), .vlow_rst(vlow_rst),
        .wr_strobe(wr_strobe), .sw_busy(sw_busy), .sw_done(sw_done),
        .wr_inhibit(wr_inhibit), .busy(busy), .auto_store_req(auto_store_req),
        .recall_req(recall_req), .ph_erase(ph_erase), .ph_prog(ph_prog),
        .ph_clear(ph_clear), .ph_xfer(ph_xfer)
    );

    // Row: inputs {sw, rs, wr, sb, sd}, edges to wait, expected
    // {busy, store, recall, inhibit}, phase nibble {erase,prog,clear,xfer}, req.
    typedef struct packed {
        int sw; int rs; int wr; int sb; int sd; int n;
        int e_busy; int e_st; int e_rc; int e_inh; int e_ph; int req;
    } row_t;

    localparam int NROWS = 44;
    localparam row_t TBL [NROWS] = '{
        '{1,0,0,0,0,2, 0,0,0,1, 4'b0000, 3},  // R3 latched, supply still low
        '{0,0,0,0,0,1, 1,0,1,1, 4'b0010, 6},  // R6 clear starts
        '{0,0,0,0,0,1, 1,0,1,1, 4'b0010, 6},  // R6
        '{0,0,0,0,0,1, 1,0,1,1, 4'b0001, 6},  // R6 transfer
        '{0,0,0,0,0,2, 1,0,1,1, 4'b0001, 6},  // R6
        '{0,0,0,0,0,1, 0,0,0,0, 4'b0000, 3},  // R3 consumed
        '{1,0,1,0,0,1, 0,0,0,1, 4'b0000, 2},  // R2 write while low
        '{1,0,0,0,0,3, 0,0,0,1, 4'b0000, 2},  // R2 ignored: no save
        '{0,0,0,0,0,1, 0,0,0,0, 4'b0000, 4},  // R4 shallow dip
        '{0,0,1,0,0,1, 0,0,0,0, 4'b0000, 8},  // R8 accepted write
        '{1,0,0,0,0,1, 1,1,0,1, 4'b0000, 7},  // R7 grace
        '{1,0,0,0,0,2, 1,1,0,1, 4'b0000, 7},  // R7
        '{1,0,0,0,0,1, 1,1,0,1, 4'b1000, 5},  // R5 erase
        '{1,0,0,0,0,3, 1,1,0,1, 4'b1000, 5},  // R5
        '{1,0,0,0,0,1, 1,1,0,1, 4'b0100, 5},  // R5 program
        '{1,0,0,0,0,4, 1,1,0,1, 4'b0100, 5},  // R5
        '{1,0,0,0,0,1, 0,0,0,1, 4'b0000, 1},  // R1 save done
        '{1,0,0,0,0,3, 0,0,0,1, 4'b0000, 1},  // R1 no second save
        '{0,0,0,0,0,1, 0,0,0,0, 4'b0000, 4},  // R4 no restore
        '{1,1,0,0,0,1, 0,0,0,1, 4'b0000, 3},  // R3 deep dip
        '{1,0,0,0,0,2, 0,0,0,1, 4'b0000, 3},  // R3
        '{0,0,0,0,0,1, 1,0,1,1, 4'b0010, 3},  // R3 restore on return
        '{0,0,0,0,0,4, 1,0,1,1, 4'b0001, 6},  // R6
        '{0,0,0,0,0,1, 0,0,0,0, 4'b0000, 6},  // R6
        '{0,0,1,0,0,1, 0,0,0,0, 4'b0000, 8},  // R8 dirty
        '{1,0,0,1,0,3, 0,0,0,1, 4'b0000, 9},  // R9 waiting
        '{1,0,0,1,1,1, 0,0,0,1, 4'b0000, 8},  // R8 software done
        '{1,0,0,0,0,2, 0,0,0,1, 4'b0000, 8},  // R8 clean: no save
        '{0,0,0,0,0,1, 0,0,0,0, 4'b0000, 9},  // R9
        '{0,0,1,0,0,1, 0,0,0,0, 4'b0000, 9},  // R9 dirty
        '{1,0,0,1,0,2, 0,0,0,1, 4'b0000, 9},  // R9 held back
        '{1,0,0,0,0,1, 1,1,0,1, 4'b0000, 9},  // R9 starts on release
        '{1,0,0,0,0,2, 1,1,0,1, 4'b0000, 7},  // R7
        '{1,0,0,0,0,1, 1,1,0,1, 4'b1000, 5},  // R5
        '{1,0,0,0,0,8, 1,1,0,1, 4'b0100, 5},  // R5
        '{1,0,0,0,0,1, 0,0,0,1, 4'b0000, 1},  // R1
        '{0,0,0,0,0,1, 0,0,0,0, 4'b0000, 10}, // R10
        '{0,0,1,0,0,1, 0,0,0,0, 4'b0000, 10}, // R10 dirty
        '{1,1,0,0,0,1, 1,1,0,1, 4'b0000, 10}, // R10 save first
        '{1,0,0,0,0,11,1,1,0,1, 4'b0100, 10}, // R10
        '{1,0,0,0,0,1, 0,0,0,1, 4'b0000, 10}, // R10 no restore yet
        '{0,0,0,0,0,1, 1,0,1,1, 4'b0010, 10}, // R10 restore on return
        '{0,0,0,0,0,4, 1,0,1,1, 4'b0001, 10}, // R10
        '{0,0,0,0,0,1, 0,0,0,0, 4'b0000, 10}  // R10
    };

    function automatic logic [7:0] obs();
        return {busy, auto_store_req, recall_req, wr_inhibit,
                ph_erase, ph_prog, ph_clear, ph_xfer};
    endfunction

    task automatic check_obs(input int req, input logic [7:0] exp_v);
        checks++;
        if (obs() !== exp_v) begin
            failures++;
            $display("FAIL R%0d at %0t: actual=%b expected=%b", req, $time, obs(), exp_v);
        end
    endtask

    task automatic drive(input int s, input int r, input int w, input int b, input int d);
        vlow_sw   = s[0];
        vlow_rst  = r[0];
        wr_strobe = w[0];
        sw_busy   = b[0];
        sw_done   = d[0];
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_obs(11, 8'b0001_0000);  // R11 reset state (inhibit from low supply)
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            drive(TBL[i].sw, TBL[i].rs, TBL[i].wr, TBL[i].sb, TBL[i].sd);
            repeat (TBL[i].n) @(posedge clk);
            #1;
            check_obs(TBL[i].req, {TBL[i].e_busy[0], TBL[i].e_st[0], TBL[i].e_rc[0],
                                   TBL[i].e_inh[0], TBL[i].e_ph[3:0]});
        end

        // Directed: write during a restore is ignored (R2).
        @(negedge clk);
        drive(1, 1, 0, 0, 0);
        @(negedge clk);
        drive(0, 0, 0, 0, 0);
        @(posedge clk); #1;
        check_obs(3, 8'b1011_0010);   // R3 restore started
        @(negedge clk);
        drive(0, 0, 1, 0, 0);         // R2 write while busy
        @(negedge clk);
        drive(0, 0, 0, 0, 0);
        repeat (4) @(posedge clk); #1;
        check_obs(6, 8'b0000_0000);   // R6 complete
        @(negedge clk);
        drive(1, 0, 0, 0, 0);
        repeat (3) @(posedge clk); #1;
        check_obs(2, 8'b0001_0000);   // R2 write was not counted: no save

        // Directed: reset in the middle of a save (R11), then power-up restore (R3).
        @(negedge clk);
        drive(0, 0, 1, 0, 0);
        @(negedge clk);
        drive(1, 0, 0, 0, 0);
        repeat (5) @(posedge clk); #1;
        check_obs(5, 8'b1101_1000);   // R5 erase in progress
        @(negedge clk);
        rst = 1'b1;
        drive(0, 0, 0, 0, 0);
        repeat (2) @(posedge clk); #1;
        check_obs(11, 8'b0000_0000);  // R11 reset aborts
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check_obs(3, 8'b1011_0010);   // R3 power-up restore
        repeat (5) @(posedge clk); #1;
        check_obs(3, 8'b0000_0000);   // R3 done
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule